// File: doc/BRIEF.md
# Serial Slave Front End with Pause and Address Strap

This block is the serial receive and transmit front end of a small register-based peripheral. It works in the system clock domain. The serial clock, chip select, data input and pause input are brought in through synchronizer stages, and edges of the serial clock are detected from the synchronized copy. Each framed transaction begins with a slave-address byte. An instruction byte follows, and then either data bytes that the host writes or read bytes that the slave returns. Bytes travel most significant bit first.

The first byte is compared with a 7-bit parameter followed by a strap pin, which lets two slaves share one bus. The instruction byte is split into an opcode and a register select, and these reach the register logic on a one-cycle strobe. Write data bytes come out on their own strobe. For a read opcode, the register logic presents a byte on `rdData`. The slave captures it on a serial clock falling edge and shifts it out on `soOut`, with `soEn` as the tri-state enable. While the pause input is low, the transaction is frozen in place. After reset the slave ignores all traffic until it sees chip select fall.

Top module: `spi_hold_slave`

## Requirements
- R1: SI is sampled on rising SCK edges, MSB first. In a matched frame, the second byte raises `cmdValid` with `cmdOpcode` = byte[7:4] and `cmdSel` = byte[3:2]; bits [1:0] are ignored.
- R2: For any opcode other than the read opcode (4'b1001), every further complete byte raises `dataValid` with that byte on `dataByte`.
- R3: After the read opcode, `soOut` carries `rdData` MSB first and changes only on falling SCK edges. The first bit follows the falling edge that ends the instruction byte. `rdData` is captured again on every eighth falling edge after that.
- R4: `soEn` is low while CS is high, before the first read bit is launched, and for the whole of any frame that is not a read.
- R5: After reset, SCK traffic has no effect until CS has gone from high to low. A frame sent while CS is held low from reset produces no strobe.
- R6: When HOLD is low and SCK is low, the slave pauses. In the pause SCK edges are ignored, the bit position is kept and `soEn` is low. After HOLD returns high with SCK low, the byte continues from where it stopped.
- R7: A HOLD change that occurs while SCK is high is not acted on until SCK is low, so a HOLD pulse confined to an SCK high phase leaves `soEn` and the transfer untouched.
- R8: The first byte must equal {ADDR_HI, addrStrap}, with ADDR_HI = 7'h28 by default. On a mismatch no strobe is produced and `soEn` stays low until CS goes high.
- R9: CS going high aborts the frame. A partly received instruction is dropped, and the next frame starts again from bit 0.
- R10: `cmdValid` and `dataValid` are each high for exactly one clock cycle per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrStrap | input | 1 | Strap supplying the LSB of the slave address |
| sckIn | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| siIn | input | 1 | Serial data in |
| holdN | input | 1 | Active-low pause |
| rdData | input | 8 | Byte to return during a read |
| soOut | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for soOut; low means high impedance |
| cmdValid | output | 1 | One-cycle strobe for a decoded instruction |
| cmdOpcode | output | 4 | Opcode field of the instruction |
| cmdSel | output | 2 | Register-select field of the instruction |
| dataValid | output | 1 | One-cycle strobe for a received data byte |
| dataByte | output | 8 | Received data byte |

## Verification
The hardest cases to reach are a pause that lands in the middle of a byte and a pause pulse that stays inside one SCK high phase. The first must keep the bit position across SCK edges that ought to be ignored. The second must have no effect at all. The bench puts both inside read bytes and write bytes. During the pause it sends extra SCK pulses carrying inverted SI, then checks that the byte still arrives intact and that `soEn` fell only during the real pause. The unarmed state after reset is reached by holding CS low through reset and sending a complete valid frame, which must produce nothing.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_READ, ST_SKIP
  } spiState_t;

  typedef struct packed {
    logic shiftIn;   // take one SI bit
    logic launch;    // present next SO bit
    logic clear;     // deselected: reset counters
    logic hold;      // transfer paused
    logic emitCmd;   // instruction byte complete
    logic emitData;  // write data byte complete
  } spiCtl_t;
endpackage

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [6:0]        ADDR_HI     = 7'h28,
  parameter logic [OP_W-1:0]   RD_OPCODE   = 4'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csN,
  input  logic              siIn,
  input  logic              holdN,
  input  logic              addrStrap,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic              byteDone,
  output spiCtl_t           ctl,
  output logic              siBit
);
  logic [SYNC_STAGES-1:0] sckPipe, csPipe, siPipe, holdPipe;
  logic sckS, csS, holdS;
  logic sckPrev, csPrev, paused;
  logic sckRise, sckFall, csFall, live, done;
  spiState_t state, stateNext;

  assign sckS  = sckPipe[SYNC_STAGES-1];
  assign csS   = csPipe[SYNC_STAGES-1];
  assign holdS = holdPipe[SYNC_STAGES-1];
  assign siBit = siPipe[SYNC_STAGES-1];

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csFall  = ~csS & csPrev;
  assign live    = ~csS & ~paused;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      csPipe   <= '0;   // low: a held-low CS never shows a falling edge
      siPipe   <= '0;
      holdPipe <= '1;
      sckPrev  <= 1'b0;
      csPrev   <= 1'b0;
      paused   <= 1'b0;
      state    <= ST_IDLE;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      siPipe   <= {siPipe[SYNC_STAGES-2:0], siIn};
      holdPipe <= {holdPipe[SYNC_STAGES-2:0], holdN};
      sckPrev  <= sckS;
      csPrev   <= csS;
      if (csS)       paused <= 1'b0;
      else if (!sckS) paused <= ~holdS;
      state    <= stateNext;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.clear    = csS;
    ctl.hold     = paused;
    ctl.shiftIn  = live & sckRise &
                   (state == ST_ADDR || state == ST_INSTR || state == ST_DATA);
    ctl.launch   = live & sckFall & (state == ST_READ);
    done         = ctl.shiftIn & byteDone;
    ctl.emitCmd  = done & (state == ST_INSTR);
    ctl.emitData = done & (state == ST_DATA);
  end

  always_comb begin
    stateNext = state;
    if (csS) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (csFall) stateNext = ST_ADDR;
        ST_ADDR:  if (done)
                    stateNext = (rxNext == {ADDR_HI, addrStrap}) ? ST_INSTR : ST_SKIP;
        ST_INSTR: if (done)
                    stateNext = (rxNext[BYTE_W-1 -: OP_W] == RD_OPCODE) ? ST_READ : ST_DATA;
        default:  stateNext = state;
      endcase
    end
  end

  AST_ARMED_BY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !csFall) |=> (state == ST_IDLE)); // R5
  AST_SKIP_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |=> (state == ST_SKIP || state == ST_IDLE)); // R8
  AST_HOLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(paused) && !$past(csS) && !csS) |-> !$past(sckS)); // R7
endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  spiCtl_t           ctl,
  input  logic              siBit,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic              byteDone,
  output logic              soOut,
  output logic              soEn,
  output logic              cmdValid,
  output logic [OP_W-1:0]   cmdOpcode,
  output logic [SEL_W-1:0]  cmdSel,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte
);
  logic [CNT_W-1:0]  bitCnt, outCnt;
  logic [BYTE_W-1:0] rxShift, outShift;
  logic              soActive;

  assign rxNext   = {rxShift[BYTE_W-2:0], siBit};
  assign byteDone = (bitCnt == CNT_W'(BYTE_W-1));
  assign soOut    = outShift[BYTE_W-1];
  assign soEn     = soActive & ~ctl.hold & ~ctl.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxShift  <= '0;
    end else if (ctl.clear) begin
      bitCnt   <= '0;
    end else if (ctl.shiftIn) begin
      bitCnt   <= bitCnt + 1'b1;
      rxShift  <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outCnt   <= '0;
      outShift <= '0;
      soActive <= 1'b0;
    end else if (ctl.clear) begin
      outCnt   <= '0;
      soActive <= 1'b0;
    end else if (ctl.launch) begin
      outCnt   <= outCnt + 1'b1;
      soActive <= 1'b1;
      outShift <= (outCnt == '0) ? rdData : {outShift[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      dataValid <= 1'b0;
      cmdOpcode <= '0;
      cmdSel    <= '0;
      dataByte  <= '0;
    end else begin
      cmdValid  <= ctl.emitCmd;
      dataValid <= ctl.emitData;
      if (ctl.emitCmd) begin
        cmdOpcode <= rxNext[BYTE_W-1 -: OP_W];
        cmdSel    <= rxNext[BYTE_W-OP_W-1 -: SEL_W];
      end
      if (ctl.emitData) dataByte <= rxNext;
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R10
  AST_DATA_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid); // R10
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hold && !ctl.clear) |=> $stable(bitCnt)); // R6
  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (soEn && $past(soEn) && !$past(ctl.launch)) |-> $stable(soOut)); // R3
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [6:0]      ADDR_HI     = 7'h28,
  parameter logic [3:0]      RD_OPCODE   = 4'h9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrStrap,
  input  logic       sckIn,
  input  logic       csN,
  input  logic       siIn,
  input  logic       holdN,
  input  logic [7:0] rdData,
  output logic       soOut,
  output logic       soEn,
  output logic       cmdValid,
  output logic [3:0] cmdOpcode,
  output logic [1:0] cmdSel,
  output logic       dataValid,
  output logic [7:0] dataByte
);
  spiCtl_t           ctl;
  logic              siBit, byteDone;
  logic [BYTE_W-1:0] rxNext;

  spi_hold_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_HI(ADDR_HI), .RD_OPCODE(RD_OPCODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csN(csN), .siIn(siIn),
    .holdN(holdN), .addrStrap(addrStrap), .rxNext(rxNext),
    .byteDone(byteDone), .ctl(ctl), .siBit(siBit)
  );

  spi_hold_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .siBit(siBit), .rdData(rdData),
    .rxNext(rxNext), .byteDone(byteDone), .soOut(soOut), .soEn(soEn),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdSel(cmdSel),
    .dataValid(dataValid), .dataByte(dataByte)
  );
endmodule

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb;
  localparam int HALF = 10;
  localparam int NONE = -1;

  logic clk = 1'b0, rstN = 1'b0;
  logic addrStrap = 1'b1, sckIn = 1'b0, csN = 1'b0, siIn = 1'b0, holdN = 1'b1;
  logic [7:0] rdData = 8'h00;
  logic soOut, soEn, cmdValid, dataValid;
  logic [3:0] cmdOpcode;
  logic [1:0] cmdSel;
  logic [7:0] dataByte;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [8:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  spi_hold_slave u_dut (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .sckIn(sckIn), .csN(csN),
    .siIn(siIn), .holdN(holdN), .rdData(rdData), .soOut(soOut), .soEn(soEn),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdSel(cmdSel),
    .dataValid(dataValid), .dataByte(dataByte)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushCmd(input string tag, input logic [3:0] op, input logic [1:0] sel);
    expQ.push_back({1'b0, op, sel, 2'b00});
    tagQ.push_back(tag);
  endtask

  task automatic pushData(input string tag, input logic [7:0] b);
    expQ.push_back({1'b1, b});
    tagQ.push_back(tag);
  endtask

  // Scoreboard monitor
  logic prevCmd = 1'b0, prevData = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid && prevCmd) chk("R10 cmd strobe width", 9'd2, 9'd1);
      if (dataValid && prevData) chk("R10 data strobe width", 9'd2, 9'd1);
      if ((cmdValid && !prevCmd) || (dataValid && !prevData)) begin
        logic [8:0] got;
        got = cmdValid ? {1'b0, cmdOpcode, cmdSel, 2'b00} : {1'b1, dataByte};
        if (expQ.size() == 0) chk("R5/R8/R9 unexpected strobe", got, 9'h1FF);
        else chk(tagQ.pop_front(), got, expQ.pop_front());
      end
      prevCmd  = cmdValid;
      prevData = dataValid;
    end
  end

  // One byte; optional pause before bit holdLowAt, optional high-phase HOLD pulse at bit holdHighAt
  task automatic xfer(input logic [7:0] tx, input logic [7:0] nextRd, input int holdLowAt,
                      input int holdHighAt, input logic driving, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (i == holdLowAt) begin
        holdN = 1'b0; waitClk(HALF);
        chk("R6 soEn low in pause", {8'h0, soEn}, 9'h0);
        for (int k = 0; k < 2; k++) begin
          siIn = ~tx[i]; waitClk(HALF); sckIn = 1'b1; waitClk(HALF); sckIn = 1'b0;
        end
        waitClk(HALF); holdN = 1'b1; waitClk(HALF);
      end
      siIn = tx[i]; waitClk(HALF); sckIn = 1'b1; waitClk(HALF);
      if (i == holdHighAt) begin
        holdN = 1'b0; waitClk(HALF);
        chk("R7 soEn unchanged by HOLD in SCK high", {8'h0, soEn}, {8'h0, driving});
        holdN = 1'b1; waitClk(HALF);
      end
      rx[i] = soOut;
      if (i == 7) rdData = nextRd;
      sckIn = 1'b0;
    end
  endtask

  task automatic frameStart();
    csN = 1'b1; waitClk(2 * HALF); csN = 1'b0; waitClk(HALF);
  endtask

  task automatic frameEnd();
    waitClk(HALF); csN = 1'b1; waitClk(2 * HALF);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rx;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    chk("R4 reset soEn", {8'h0, soEn}, 9'h0);
    chk("R10 reset cmdValid", {8'h0, cmdValid}, 9'h0);

    // R5: CS low since reset, full valid frame must be ignored
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h3C, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'hC3, rdData, NONE, NONE, 1'b0, rx);
    waitClk(HALF);
    chk("R5 unarmed no strobe", 9'(expQ.size()), 9'd0);
    chk("R5 unarmed soEn", {8'h0, soEn}, 9'h0);
    frameEnd();

    // R1, R2: write with two data bytes
    frameStart();
    pushCmd("R1 write cmd", 4'h3, 2'h3);
    pushData("R2 data byte 1", 8'hC3);
    pushData("R2 data byte 2", 8'h5A);
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h3F, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'hC3, rdData, NONE, NONE, 1'b0, rx);
    chk("R4 soEn low in write frame", {8'h0, soEn}, 9'h0);
    xfer(8'h5A, rdData, NONE, NONE, 1'b0, rx);
    frameEnd();
    chk("R2 all write items seen", 9'(expQ.size()), 9'd0);

    // R3, R4: read two bytes
    rdData = 8'hB6;
    frameStart();
    pushCmd("R1 read cmd", 4'h9, 2'h1);
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    chk("R4 soEn low before launch", {8'h0, soEn}, 9'h0);
    xfer(8'h94, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h00, 8'h2D, NONE, NONE, 1'b1, rx);
    chk("R3 read byte 1", {1'b0, rx}, 9'h0B6);
    xfer(8'h00, 8'h2D, NONE, NONE, 1'b1, rx);
    chk("R3 read byte 2", {1'b0, rx}, 9'h02D);
    frameEnd();
    chk("R4 soEn low after CS high", {8'h0, soEn}, 9'h0);

    // R6: pause mid write byte
    frameStart();
    pushCmd("R6 cmd", 4'h2, 2'h0);
    pushData("R6 data after pause", 8'hE7);
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h20, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'hE7, rdData, 4, NONE, 1'b0, rx);
    frameEnd();
    chk("R6 write items seen", 9'(expQ.size()), 9'd0);

    // R6, R7: pause and high-phase HOLD pulse in a read
    rdData = 8'h71;
    frameStart();
    pushCmd("R7 read cmd", 4'h9, 2'h3);
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h9C, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h00, 8'h8E, 3, 5, 1'b1, rx);
    chk("R6 read byte across pause", {1'b0, rx}, 9'h071);
    xfer(8'h00, 8'h8E, NONE, 2, 1'b1, rx);
    chk("R7 read byte with high-phase pulse", {1'b0, rx}, 9'h08E);
    frameEnd();

    // R8: address mismatch, then strap-selected address
    frameStart();
    xfer(8'h50, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h94, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h00, rdData, NONE, NONE, 1'b0, rx);
    chk("R8 mismatch soEn", {8'h0, soEn}, 9'h0);
    frameEnd();
    chk("R8 mismatch no strobe", 9'(expQ.size()), 9'd0);
    addrStrap = 1'b0;
    frameStart();
    pushCmd("R8 strap 0 match", 4'h3, 2'h2);
    xfer(8'h50, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h38, rdData, NONE, NONE, 1'b0, rx);
    frameEnd();
    addrStrap = 1'b1;

    // R9: abort mid instruction, then clean frame
    frameStart();
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    for (int i = 7; i >= 3; i--) begin
      siIn = 1'b1; waitClk(HALF); sckIn = 1'b1; waitClk(HALF); sckIn = 1'b0;
    end
    frameEnd();
    chk("R9 aborted command dropped", 9'(expQ.size()), 9'd0);
    frameStart();
    pushCmd("R9 frame after abort", 4'h4, 2'h2);
    xfer(8'h51, rdData, NONE, NONE, 1'b0, rx);
    xfer(8'h48, rdData, NONE, NONE, 1'b0, rx);
    frameEnd();
    chk("R9 scoreboard drained", 9'(expQ.size()), 9'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule